// File: doc/BRIEF.md
# Edge-Timed Window Watchdog

This block watches a heartbeat line that a processor toggles while its software runs normally. Every transition of the heartbeat, rising or falling, ends one interval and starts the next. The interval is counted in cycles of the watchdog clock. An interval that closes before the fast bound is a fault: the software is running away or stuck in a tight loop. A gap that reaches the slow bound with no transition is also a fault: the software has hung. Each fault is sent to the reset controller as a one-cycle pulse, and the reset controller then pulls the system reset low.

The watchdog is armed only when three conditions hold together: the enable input is high, the system reset is released, and the power-up self-test has passed. A registered copy of this armed condition is driven out, so the board can see whether supervision is running. While the block is disarmed, its interval counter is held at its start value and no fault can be raised. The heartbeat passes through a synchronizer chain and an edge detector before it is timed. Both timeout bounds are parameters, counted in watchdog clock cycles.

Top module: `hb_window_wdog`

## Requirements
- R1: `wd_armed_o` equals the AND of `wd_en_i`, `sys_rst_n_i` and `selftest_ok_i`, as sampled at the previous clock edge (one register of latency).
- R2: While `rst` is high, and in the first cycle after it falls, `wd_armed_o` and `wd_fault_o` are both 0.
- R3: Rising and falling heartbeat transitions both end an interval. A transition driven between edges X and X+1 is judged at edge X+3 (SYNC_STAGES = 2). The interval is the number of clock edges between the edges that judge two successive transitions.
- R4: An interval shorter than FAST_CYC produces a fault pulse. The pulse is visible right after the edge that judges the transition.
- R5: An interval from FAST_CYC to SLOW_CYC, both ends included, produces no fault.
- R6: If SLOW_CYC edges pass after the last transition, fault or arming with no transition judged, a fault pulse is raised on that edge. Timing then restarts, so an idle heartbeat faults once every SLOW_CYC cycles.
- R7: Each fault is a pulse one cycle wide. After each fault, the interval count restarts from that edge.
- R8: While the block is disarmed (any one of the three arming inputs low), `wd_fault_o` stays 0 whatever the heartbeat does.
- R9: Arming starts a fresh interval at the edge where `wd_armed_o` rises. The first transition after arming is checked against the window like any later one. Disarming in the middle of an interval throws away the time already counted.
- R10: `wd_fault_o` is high only when `wd_armed_o` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en_i | input | 1 | Watchdog enable pin |
| sys_rst_n_i | input | 1 | System reset state, high when reset is released |
| selftest_ok_i | input | 1 | High when the power-up self-test has passed |
| hb_i | input | 1 | Processor heartbeat, asynchronous toggling line |
| wd_armed_o | output | 1 | Buffered enable: high while the watchdog is armed |
| wd_fault_o | output | 1 | One-cycle fault pulse to the reset controller |

## Verification
The bench sweeps the interval from one cycle up to twice the slow bound, with small bounds. It checks the number of fault pulses and their exact cycles. A design that treats either bound as exclusive, or that times only one edge polarity, faults at the wrong interval lengths. The sweep also covers intervals that first overrun the slow bound and then close soon after the late fault. This catches a design that keeps counting from the earlier transition instead of from the fault. A separate test checks that an idle heartbeat faults at regular spacing: a counter that saturates instead of restarting gives only one pulse. Other tests check that the first transition after arming is judged from the arming edge, and that disarming part way through discards the elapsed time. A design with either fault would pass early edges, or time out too soon after re-arming.

// File: rtl/hb_wdog_pkg.sv
package hb_wdog_pkg;

    // Outcome of judging one watchdog clock cycle.
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_GOOD  = 2'd1,
        WIN_EARLY = 2'd2,
        WIN_LATE  = 2'd3
    } win_verdict_e;

    // Per-cycle result handed from the judging logic to the state update.
    typedef struct packed {
        win_verdict_e verdict;
        logic         restart;
        logic         violation;
    } win_step_t;

    // Classify a cycle from the edge strobe and the cycles elapsed so far.
    function automatic win_verdict_e judge_window(
        input logic        edge_seen,
        input int unsigned elapsed,
        input int unsigned fast_bound,
        input int unsigned slow_bound
    );
        win_verdict_e v;
        if (edge_seen) begin
            v = (elapsed < fast_bound) ? WIN_EARLY : WIN_GOOD;
        end else begin
            v = (elapsed >= slow_bound) ? WIN_LATE : WIN_IDLE;
        end
        return v;
    endfunction

    function automatic logic is_violation(input win_verdict_e v);
        return (v == WIN_EARLY) || (v == WIN_LATE);
    endfunction

endpackage

// File: rtl/hb_wdog_sync_edge.sv
module hb_wdog_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hb_i,
    output logic edge_o
);
    localparam int FILL_W = SYNC_STAGES + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic [FILL_W-1:0]      fill_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= hb_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // The fill chain masks edges until the synchronizer holds real samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            fill_q <= '0;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
            fill_q <= {fill_q[FILL_W-2:0], 1'b1};
        end
    end

    assign edge_o = fill_q[FILL_W-1] & (sync_q[SYNC_STAGES-1] ^ last_q);

endmodule

// File: rtl/hb_wdog_arm_gate.sv
module hb_wdog_arm_gate (
    input  logic clk,
    input  logic rst,
    input  logic wd_en_i,
    input  logic sys_rst_n_i,
    input  logic selftest_ok_i,
    output logic armed_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= wd_en_i & sys_rst_n_i & selftest_ok_i;
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/hb_wdog_window_timer.sv
module hb_wdog_window_timer
    import hb_wdog_pkg::*;
#(
    parameter int FAST_CYC = 4,
    parameter int SLOW_CYC = 10,
    parameter int CNT_W    = $clog2(SLOW_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed_i,
    input  logic             edge_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             fault_q;
    win_step_t        step;

    always_comb begin
        step.verdict   = judge_window(edge_i, 32'(cnt_q),
                                      FAST_CYC, SLOW_CYC);
        step.violation = is_violation(step.verdict);
        step.restart   = (step.verdict != WIN_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_START;
            fault_q <= 1'b0;
        end else if (!armed_i) begin
            cnt_q   <= CNT_START;
            fault_q <= 1'b0;
        end else begin
            fault_q <= step.violation;
            cnt_q   <= step.restart ? CNT_START : cnt_q + CNT_W'(1);
        end
    end

    assign fault_o = fault_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/hb_window_wdog.sv
module hb_window_wdog #(
    parameter int FAST_CYC    = 200,
    parameter int SLOW_CYC    = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_en_i,
    input  logic sys_rst_n_i,
    input  logic selftest_ok_i,
    input  logic hb_i,
    output logic wd_armed_o,
    output logic wd_fault_o
);
    localparam int CNT_W = $clog2(SLOW_CYC + 1);

    logic             hb_edge;
    logic             armed;
    logic [CNT_W-1:0] win_cnt;

    hb_wdog_sync_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .hb_i  (hb_i),
        .edge_o(hb_edge)
    );

    hb_wdog_arm_gate arm_i (
        .clk          (clk),
        .rst          (rst),
        .wd_en_i      (wd_en_i),
        .sys_rst_n_i  (sys_rst_n_i),
        .selftest_ok_i(selftest_ok_i),
        .armed_o      (armed)
    );

    hb_wdog_window_timer #(
        .FAST_CYC(FAST_CYC),
        .SLOW_CYC(SLOW_CYC),
        .CNT_W   (CNT_W)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .armed_i(armed),
        .edge_i (hb_edge),
        .fault_o(wd_fault_o),
        .cnt_o  (win_cnt)
    );

    assign wd_armed_o = armed;

endmodule

// File: rtl/hb_window_wdog_chk.sv
module hb_window_wdog_chk #(
    parameter int FAST_CYC = 4,
    parameter int SLOW_CYC = 10,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wd_en_i,
    input logic             sys_rst_n_i,
    input logic             selftest_ok_i,
    input logic             wd_armed_o,
    input logic             wd_fault_o,
    input logic             edge_i,
    input logic [CNT_W-1:0] cnt_i
);
    localparam logic [CNT_W-1:0] FAST_C = CNT_W'(FAST_CYC);
    localparam logic [CNT_W-1:0] SLOW_C = CNT_W'(SLOW_CYC);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    AST_ARM_FOLLOWS_INPUTS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> wd_armed_o == $past(wd_en_i && sys_rst_n_i && selftest_ok_i)); // R1

    AST_FAULT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        wd_fault_o |-> $past(wd_armed_o)); // R10

    AST_EARLY_EDGE_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (edge_i && wd_armed_o && cnt_i < FAST_C) |=> wd_fault_o); // R4

    AST_WINDOW_EDGE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (edge_i && wd_armed_o && cnt_i >= FAST_C) |=> !wd_fault_o); // R5

    AST_LATE_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (!edge_i && wd_armed_o && cnt_i == SLOW_C) |=> wd_fault_o); // R6

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_i >= ONE_C && cnt_i <= SLOW_C); // R6

    AST_RESTART_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
        wd_fault_o |-> cnt_i == ONE_C); // R7

    AST_DISARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wd_armed_o |=> cnt_i == ONE_C && !wd_fault_o); // R8

endmodule

bind hb_window_wdog hb_window_wdog_chk #(
    .FAST_CYC(FAST_CYC),
    .SLOW_CYC(SLOW_CYC),
    .CNT_W   (CNT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wd_en_i      (wd_en_i),
    .sys_rst_n_i  (sys_rst_n_i),
    .selftest_ok_i(selftest_ok_i),
    .wd_armed_o   (wd_armed_o),
    .wd_fault_o   (wd_fault_o),
    .edge_i       (hb_edge),
    .cnt_i        (win_cnt)
);

// File: tb/hb_window_wdog_tb_top.sv
module hb_window_wdog_tb_top;
    localparam int FAST = 4;
    localparam int SLOW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, sysok = 1'b0, stok = 1'b0, hb = 1'b0;
    logic armed, fault;

    int checks = 0, fails = 0, cyc = 0, ref_c = 0;
    int nf = 0, sumoff = 0, firstoff = -1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hb_window_wdog #(.FAST_CYC(FAST), .SLOW_CYC(SLOW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .wd_en_i(en), .sys_rst_n_i(sysok),
        .selftest_ok_i(stok), .hb_i(hb), .wd_armed_o(armed), .wd_fault_o(fault)
    );

    // One clock edge; outputs sampled 1 ns after it, fault cycles logged.
    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
        if (fault === 1'b1) begin
            nf++;
            sumoff += cyc - ref_c;
            if (firstoff < 0) firstoff = cyc - ref_c;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clr();
        nf = 0; sumoff = 0; firstoff = -1; ref_c = cyc;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Disarm briefly, then arm; returns with cyc at the arming edge.
    task automatic arm();
        en = 1'b0; sysok = 1'b1; stok = 1'b1;
        ticks(3);
        en = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int exp_n, exp_sum;
        ticks(4);
        chk("R2", "armed in reset", armed, 0);
        chk("R2", "fault in reset", fault, 0);
        rst = 1'b0;
        tick();
        chk("R2", "armed after reset", armed, 0);
        chk("R2", "fault after reset", fault, 0);
        ticks(2);

        // R1: every combination of the three arming inputs
        for (int v = 0; v < 8; v++) begin
            en = v[2]; sysok = v[1]; stok = v[0];
            tick();
            chk("R1", $sformatf("armed for inputs %0d", v), armed, (v == 7) ? 1 : 0);
        end

        // R6 / R7: idle heartbeat faults every SLOW cycles, one cycle wide
        arm(); clr();
        ticks(3 * SLOW);
        chk("R6", "late fault count", nf, 3);
        chk("R6", "first late offset", firstoff, SLOW);
        chk("R7", "late offset sum (restart spacing)", sumoff, 6 * SLOW);

        // R9: first transition after arming is judged from the arming edge
        arm(); clr();
        hb = ~hb;
        ticks(6);
        chk("R9", "early first edge faults", nf, 1);
        chk("R9", "early first edge offset", firstoff, 3);
        arm(); clr();
        ticks(FAST - 3);
        hb = ~hb;
        ticks(6);
        chk("R9", "first edge at fast bound clean", nf, 0);

        // R3 / R4 / R5 / R6: sweep of the interval between two transitions
        for (int t = 1; t <= 2 * SLOW; t++) begin
            arm();
            ticks(FAST - 2);
            hb = ~hb;
            clr();
            for (int k = 1; k <= t + 5; k++) begin
                tick();
                if (k == t) hb = ~hb;
            end
            exp_n = 0; exp_sum = 0;
            if (t > SLOW) begin exp_n++; exp_sum += 3 + SLOW; end
            if (t < FAST || (t > SLOW && t - SLOW < FAST)) begin
                exp_n++; exp_sum += 3 + t;
            end
            chk((t < FAST) ? "R4" : ((t <= SLOW) ? "R5" : "R6"),
                $sformatf("fault count interval %0d", t), nf, exp_n);
            chk("R3", $sformatf("fault timing interval %0d", t), sumoff, exp_sum);
        end

        // R8 / R10: each disarming input alone suppresses faults
        for (int m = 0; m < 3; m++) begin
            en = (m != 0); sysok = (m != 1); stok = (m != 2);
            tick(); clr();
            for (int k = 0; k < 10; k++) begin hb = ~hb; tick(); end
            ticks(3 * SLOW);
            chk("R8", $sformatf("no fault while disarmed case %0d", m), nf, 0);
            chk("R10", $sformatf("armed low case %0d", m), armed, 0);
        end

        // R9: disarming mid-interval discards elapsed time
        arm();
        ticks(SLOW - 2);
        en = 1'b0;
        ticks(3);
        en = 1'b1;
        tick(); clr();
        ticks(SLOW + 1);
        chk("R9", "re-arm fault count", nf, 1);
        chk("R9", "re-arm late offset", firstoff, SLOW);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule